// File: doc/BRIEF.md
# Selectable Sample Output Formatter

This block sits after a sampling core that produces unsigned, offset-binary sample words with a valid strobe. It re-codes each accepted word into one of three output codings: plain offset binary, two's complement, or Gray code. The result goes through a single register stage. The coding is picked at run time. The normal source is a three-level strapping pin, whose level a pad detector has already turned into a two-bit code. A software-written override, made of a valid bit and a two-bit format code, replaces the pin whenever that valid bit is set.

Two's complement is the offset-binary word with only its top bit inverted. The Gray word keeps the top bit and replaces every lower bit with the XOR of that bit and the bit just above it. The shared package also provides the inverse conversion, a ripple from the top bit down, which turns a Gray word back into offset binary. Reference models and checkers can use that function.

Top module: `sample_coder`

## Requirements
- R1: While reset is high and on the first cycle after reset, out_word is 0 and out_valid is 0.
- R2: out_valid goes high exactly one clock after a cycle with in_valid high. On that same edge out_word takes the re-coded value of the word accepted on that cycle.
- R3: After a cycle with in_valid low, out_valid is low on the next cycle and out_word keeps its previous value. Changes to in_word and to the format inputs during such cycles have no effect on out_word.
- R4: In offset-binary format, out_word equals the accepted in_word. 0x000, 0x800 and 0xFFF pass unchanged.
- R5: In two's-complement format, out_word is in_word with only bit 11 inverted. 0x800 gives 0x000, 0xFFF gives 0x7FF and 0x000 gives 0x800.
- R6: In Gray format, out bit 11 equals in bit 11, and out bit i equals in bit i XOR in bit i+1 for i from 0 to 10. 0x800 gives 0xC00 and 0xFFF gives 0x800.
- R7: The package function gray_to_bin returns the original offset-binary word for the Gray code of each of the 4096 words. Gray outputs of consecutive input words differ in exactly one bit.
- R8: When ovr_valid is 0, the pin code picks the format: 0 (pin low) gives offset binary, 1 (pin floating) gives two's complement, 2 (pin high) gives Gray, and the unused code 3 gives offset binary.
- R9: When ovr_valid is 1, ovr_fmt picks the format using the same code map, whatever the pin code is.
- R10: The format used for a sample is the one present on the cycle that sample is accepted. A change takes effect on the first sample accepted after it, and does not alter a word already in the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 12 | Offset-binary sample |
| in_valid | input | 1 | Sample strobe |
| pin_code | input | 2 | Decoded level of the three-level format pin (0 low, 1 float, 2 high) |
| ovr_valid | input | 1 | Register override enable |
| ovr_fmt | input | 2 | Register override format code (0 offset, 1 two's complement, 2 Gray) |
| out_word | output | 12 | Re-coded sample |
| out_valid | output | 1 | Output strobe, one clock after in_valid |

## Verification
The in-design assertions check on every cycle that the strobe has a one-cycle latency and that the output holds while idle. They also check, for whichever format was active when a word was accepted, that the registered word maps back to that input: directly for offset binary, through the top-bit inversion for two's complement, and through the ripple decoder for Gray. The priority of the override over the pin, the handling of the unused code 3, and the one-bit-step property of the Gray sequence are shown only by the bench. It sweeps all 4096 words through both selection paths and applies format changes between samples.

// File: rtl/sample_coder_pkg.sv
package sample_coder_pkg;

    localparam int SAMPLE_W = 12;

    typedef enum logic [1:0] {
        FMT_OBIN = 2'd0,
        FMT_TWOS = 2'd1,
        FMT_GRAY = 2'd2
    } fmt_e;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] word;
    } sample_t;

    // Shared code map for the pin and the override; the unused code falls back to offset binary.
    function automatic fmt_e code_to_fmt(input logic [1:0] code);
        case (code)
            2'd1:    return FMT_TWOS;
            2'd2:    return FMT_GRAY;
            default: return FMT_OBIN;
        endcase
    endfunction

    // Ripple from the top bit: each binary bit is its Gray bit XOR the binary bit above.
    function automatic logic [SAMPLE_W-1:0] gray_to_bin(input logic [SAMPLE_W-1:0] g);
        logic [SAMPLE_W-1:0] b;
        b[SAMPLE_W-1] = g[SAMPLE_W-1];
        for (int i = SAMPLE_W - 2; i >= 0; i--) begin
            b[i] = g[i] ^ b[i+1];
        end
        return b;
    endfunction

endpackage

// File: rtl/sample_coder_sel.sv
module sample_coder_sel
    import sample_coder_pkg::*;
(
    input  logic [1:0] pin_code,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_fmt,
    output fmt_e       fmt
);
    fmt_e pin_fmt;
    fmt_e reg_fmt;

    always_comb begin
        pin_fmt = code_to_fmt(pin_code);
        reg_fmt = code_to_fmt(ovr_fmt);
        fmt     = ovr_valid ? reg_fmt : pin_fmt;
    end
endmodule

// File: rtl/sample_coder_enc.sv
module sample_coder_enc
    import sample_coder_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic [W-1:0] bin,
    input  fmt_e         fmt,
    output logic [W-1:0] coded
);
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] gray;
    logic [W-1:0] twos;

    assign gray[W-1] = bin[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_gray
        assign gray[i] = bin[i] ^ bin[i+1];
    end

    assign twos = bin ^ MSB_MASK;

    always_comb begin
        case (fmt)
            FMT_TWOS: coded = twos;
            FMT_GRAY: coded = gray;
            default:  coded = bin;
        endcase
    end
endmodule

// File: rtl/sample_coder.sv
module sample_coder
    import sample_coder_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_word,
    input  logic         in_valid,
    input  logic [1:0]   pin_code,
    input  logic         ovr_valid,
    input  logic [1:0]   ovr_fmt,
    output logic [W-1:0] out_word,
    output logic         out_valid
);
    fmt_e         sel_fmt;
    logic [W-1:0] coded;
    sample_t      stage_q;

    sample_coder_sel u_sel (
        .pin_code  (pin_code),
        .ovr_valid (ovr_valid),
        .ovr_fmt   (ovr_fmt),
        .fmt       (sel_fmt)
    );

    sample_coder_enc #(.W(W)) u_enc (
        .bin   (in_word),
        .fmt   (sel_fmt),
        .coded (coded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.valid <= in_valid;
            if (in_valid) begin
                stage_q.word <= coded;
            end
        end
    end

    assign out_word  = stage_q.word;
    assign out_valid = stage_q.valid;

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> $stable(out_word)); // R3

    AST_OBIN_PASS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && sel_fmt == FMT_OBIN) |-> out_word == $past(in_word)); // R4

    AST_TWOS_TOP: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && sel_fmt == FMT_TWOS)
        |-> ({~out_word[W-1], out_word[W-2:0]} == $past(in_word))); // R5

    AST_GRAY_INV: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && sel_fmt == FMT_GRAY)
        |-> gray_to_bin(out_word) == $past(in_word)); // R6
endmodule

// File: tb/sample_coder_bench.sv
module sample_coder_bench;
    import sample_coder_pkg::*;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_word = '0;
    logic         in_valid = 1'b0;
    logic [1:0]   pin_code = 2'd0;
    logic         ovr_valid = 1'b0;
    logic [1:0]   ovr_fmt = 2'd0;
    logic [W-1:0] out_word;
    logic         out_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sample_coder #(.W(W)) u_sample_coder (
        .clk       (clk),
        .rst       (rst),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .pin_code  (pin_code),
        .ovr_valid (ovr_valid),
        .ovr_fmt   (ovr_fmt),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] w, input int f);
        if (f == 1) return w ^ 12'h800;
        if (f == 2) return w ^ (w >> 1);
        return w;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, check just after the capturing rising edge.
    task automatic send(input logic [W-1:0] w, input logic [1:0] pc,
                        input logic ov, input logic [1:0] of);
        @(negedge clk);
        in_word = w; pin_code = pc; ovr_valid = ov; ovr_fmt = of; in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [W-1:0] w, input logic [1:0] pc,
                        input logic ov, input logic [1:0] of);
        @(negedge clk);
        in_word = w; pin_code = pc; ovr_valid = ov; ovr_fmt = of; in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [W-1:0] prev_gray;
        logic [W-1:0] held;

        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", out_word, '0);
        check("R1 reset valid", {11'd0, out_valid}, 12'd1 - 12'd1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset word", out_word, '0);
        check("R1 after reset valid", {11'd0, out_valid}, '0);

        // Corner values through the pin path.
        send(12'h800, 2'd1, 1'b0, 2'd0); check("R5 mid twos", out_word, 12'h000);
        check("R2 valid after accept", {11'd0, out_valid}, 12'd1);
        send(12'hFFF, 2'd1, 1'b0, 2'd0); check("R5 top twos", out_word, 12'h7FF);
        send(12'h000, 2'd1, 1'b0, 2'd0); check("R5 bottom twos", out_word, 12'h800);
        send(12'h800, 2'd2, 1'b0, 2'd0); check("R6 mid gray", out_word, 12'hC00);
        send(12'hFFF, 2'd2, 1'b0, 2'd0); check("R6 top gray", out_word, 12'h800);
        send(12'h800, 2'd0, 1'b0, 2'd0); check("R4 mid obin", out_word, 12'h800);
        send(12'hABC, 2'd3, 1'b0, 2'd0); check("R8 pin code 3 obin", out_word, 12'hABC);

        // Sweep every word in each pin-selected format (R8, R4, R5, R6).
        for (int f = 0; f < 3; f++) begin
            for (int w = 0; w < 4096; w++) begin
                send(w[W-1:0], f[1:0], 1'b0, 2'd3);
                check($sformatf("R8 pin fmt %0d word %h", f, w[W-1:0]),
                      out_word, model(w[W-1:0], f));
            end
        end

        // Override sweep against a conflicting pin; Gray adjacency and round trip (R9, R7).
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 4096; w++) begin
                send(w[W-1:0], (f == 2) ? 2'd1 : 2'd2, 1'b1, f[1:0]);
                check($sformatf("R9 ovr fmt %0d word %h", f, w[W-1:0]),
                      out_word, model(w[W-1:0], (f == 3) ? 0 : f));
                if (f == 2) begin
                    check("R7 round trip", gray_to_bin(out_word), w[W-1:0]);
                    if (w > 0) begin
                        check("R7 one-bit step", $countones(out_word ^ prev_gray), 12'd1);
                    end
                    prev_gray = out_word;
                end
            end
        end

        // Idle cycles with changing inputs leave the register alone (R3, R10).
        send(12'h123, 2'd0, 1'b0, 2'd0);
        held = out_word;
        idle(12'hFFF, 2'd2, 1'b1, 2'd1);
        check("R3 idle valid low", {11'd0, out_valid}, '0);
        check("R3 idle hold", out_word, held);
        idle(12'h000, 2'd1, 1'b0, 2'd0);
        check("R10 format change keeps held word", out_word, held);
        send(12'h800, 2'd1, 1'b0, 2'd0);
        check("R10 first sample after change", out_word, 12'h000);
        send(12'h800, 2'd1, 1'b1, 2'd2);
        check("R10 override applied at next sample", out_word, 12'hC00);
        idle(12'h555, 2'd0, 1'b0, 2'd0);
        check("R3 hold after override drop", out_word, 12'hC00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule